// File: doc/BRIEF.md
# Saturation-Driven Receiver Gain Step Selector

This block sets the gain of a non-coherent energy-collection receiver. It watches a bank of integrator channels, each digitised to a small unsigned code once per symbol. From each sample set it decides whether the amplifier gain should move, and it drives a compact index that picks one of four discrete gain levels. The index goes down when several channels clip at full scale. It goes up when the whole bank reads nothing. Every other sample set leaves it where it is. The block does not aim at a target signal level.

A sample set arrives as one flat bus together with a one-cycle valid strobe. The index is registered and changes in the clock cycle after the strobe. When the index moves, a one-cycle change pulse goes with it, so downstream logic can reload the analogue control. A settled flag shows whether the most recent sample set left the gain untouched. The index starts at the highest gain after reset and saturates at both ends of its range.

Top module: `agc_gain_sel`

## Requirements
- R1: While reset is asserted and right after it is released, the gain index is 3 (highest gain), the change pulse is 0 and the settled flag is 0.
- R2: Channel k occupies bus bits [4k+3:4k] as a 4-bit unsigned code, and full scale is 4'b1111. A valid set in which two or more channels read full scale lowers the index by one in the next cycle, with the change pulse high for that one cycle. Later sets keep lowering it in the same way.
- R3: A valid set in which exactly one channel reads full scale leaves the index unchanged and gives no change pulse.
- R4: A valid set in which all eight channels read 4'b0000 raises the index by one in the next cycle, with the change pulse high for that one cycle.
- R5: At index 0 a lowering condition is ignored: the index stays 0 and no change pulse is raised.
- R6: At index 3 a raising condition is ignored: the index stays 3 and no change pulse is raised.
- R7: Each valid set moves the index by at most one step, even when every channel clips and even when sets arrive on consecutive cycles. Without a valid strobe the index holds and the change pulse stays low.
- R8: After a valid set that leaves the index unchanged, the settled flag is 1. After a valid set that changes the index, it is 0. Between valid sets the flag holds its value.
- R9: A code one below full scale (4'b1110) does not count as full scale, and a non-zero code on any channel stops a raise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Marks a cycle that carries a complete sample set |
| smp_bus | input | 32 | Eight 4-bit channel codes; channel k at bits [4k+3:4k] |
| gain_idx | output | 2 | Selected gain level, 0 lowest and 3 highest |
| gain_chg | output | 1 | One-cycle pulse in the cycle the index has just moved |
| settled | output | 1 | Last sample set left the gain unchanged |

## Verification
The bound checker recounts clipped and empty channels on its own and checks every cycle that the index steps by exactly one in the correct direction. It also checks that the index does not move past either end, that it never moves without a strobe, that the change pulse only follows a strobe, and that the settled flag follows the outcome of each set. The bench scenarios are what show the longer sequences. These are repeated lowering from the top level to the bottom, climbing back from the bottom, near-full-scale codes that must not count, and strobes on consecutive cycles. The scenarios also confirm that the reset values and the one-cycle latency seen at the ports agree with a model that knows nothing of the design.

// File: rtl/agc_gain_sel.sv
module agc_gain_sel #(
  parameter int CHANNELS = 8,
  parameter int CODE_W   = 4,
  parameter int LEVELS   = 4,
  parameter int IDX_W    = $clog2(LEVELS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_valid,
  input  logic [CHANNELS*CODE_W-1:0] smp_bus,
  output logic [IDX_W-1:0]           gain_idx,
  output logic                       gain_chg,
  output logic                       settled
);

  localparam int               CNT_W   = $clog2(CHANNELS + 1);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(LEVELS - 1);

  logic [CHANNELS-1:0] at_full, at_zero;
  logic [CNT_W-1:0]    full_cnt;
  logic                step_down, step_up;

  for (genvar g = 0; g < CHANNELS; g++) begin : g_chan
    assign at_full[g] = smp_bus[g*CODE_W +: CODE_W] == {CODE_W{1'b1}};
    assign at_zero[g] = smp_bus[g*CODE_W +: CODE_W] == '0;
  end

  always_comb begin
    full_cnt = '0;
    for (int i = 0; i < CHANNELS; i++) full_cnt = full_cnt + CNT_W'(at_full[i]);
  end

  assign step_down = smp_valid && (full_cnt >= CNT_W'(2)) && (gain_idx != '0);
  assign step_up   = smp_valid && (&at_zero) && (gain_idx != TOP_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain_idx <= TOP_IDX;
      gain_chg <= 1'b0;
      settled  <= 1'b0;
    end else begin
      gain_chg <= step_down || step_up;
      if (step_down)    gain_idx <= gain_idx - IDX_W'(1);
      else if (step_up) gain_idx <= gain_idx + IDX_W'(1);
      if (smp_valid)    settled  <= !(step_down || step_up);
    end
  end

endmodule

module agc_gain_sel_chk #(
  parameter int CHANNELS = 8,
  parameter int CODE_W   = 4,
  parameter int LEVELS   = 4,
  parameter int IDX_W    = $clog2(LEVELS)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       smp_valid,
  input logic [CHANNELS*CODE_W-1:0] smp_bus,
  input logic [IDX_W-1:0]           gain_idx,
  input logic                       gain_chg,
  input logic                       settled
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(LEVELS - 1);

  logic [CHANNELS-1:0] clip, empty;
  for (genvar g = 0; g < CHANNELS; g++) begin : g_mon
    assign clip[g]  = &smp_bus[g*CODE_W +: CODE_W];
    assign empty[g] = ~|smp_bus[g*CODE_W +: CODE_W];
  end
  logic lower_req, raise_req;
  assign lower_req = smp_valid && ($countones(clip) > 1);
  assign raise_req = smp_valid && (&empty);

  AST_STEP_DOWN:  assert property (@(posedge clk) disable iff (!rst_n)
    lower_req && gain_idx != '0 |=> gain_idx == $past(gain_idx) - IDX_W'(1) && gain_chg); // R2
  AST_STEP_UP:    assert property (@(posedge clk) disable iff (!rst_n)
    raise_req && gain_idx != TOP_IDX |=> gain_idx == $past(gain_idx) + IDX_W'(1) && gain_chg); // R4
  AST_FLOOR:      assert property (@(posedge clk) disable iff (!rst_n)
    lower_req && gain_idx == '0 |=> gain_idx == '0 && !gain_chg); // R5
  AST_CEILING:    assert property (@(posedge clk) disable iff (!rst_n)
    raise_req && gain_idx == TOP_IDX |=> gain_idx == TOP_IDX && !gain_chg); // R6
  AST_IDLE_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(gain_idx) && !gain_chg && $stable(settled)); // R7
  AST_NO_REQ:     assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !lower_req && !raise_req |=> $stable(gain_idx) && !gain_chg && settled); // R3
  AST_SETTLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    gain_chg |-> !settled); // R8
endmodule

bind agc_gain_sel agc_gain_sel_chk #(
  .CHANNELS(CHANNELS), .CODE_W(CODE_W), .LEVELS(LEVELS), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_bus(smp_bus),
  .gain_idx(gain_idx), .gain_chg(gain_chg), .settled(settled)
);

// File: tb/agc_gain_sel_bench.sv
`timescale 1ns/1ps
module agc_gain_sel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [31:0] smp_bus = '0;
  logic [1:0]  gain_idx;
  logic        gain_chg, settled;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct {
    int    idx;
    int    chg;
    int    st;
    string tag;
  } exp_t;
  exp_t sb[$];
  int ref_idx = 3;
  int ref_st  = 0;

  always #2 clk = ~clk;

  agc_gain_sel u_agc_gain_sel (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_bus(smp_bus),
    .gain_idx(gain_idx), .gain_chg(gain_chg), .settled(settled)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic send(logic [31:0] b, string tag);
    int nfull = 0, nzero = 0, chg = 0;
    exp_t e;
    @(negedge clk);
    smp_valid = 1'b1;
    smp_bus   = b;
    for (int k = 0; k < 8; k++) begin
      if (b[4*k +: 4] == 4'hF) nfull++;
      if (b[4*k +: 4] == 4'h0) nzero++;
    end
    if (nfull >= 2 && ref_idx > 0) begin ref_idx--; chg = 1; end
    else if (nzero == 8 && ref_idx < 3) begin ref_idx++; chg = 1; end
    ref_st = (chg == 0);
    e.idx = ref_idx; e.chg = chg; e.st = ref_st; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b0;
      smp_bus   = 32'h5A5A_5A5A;
    end
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      if (rst_n) begin
        if (smp_valid) begin
          #1;
          if (sb.size() == 0) chk("R7", "unexpected result", 1, 0);
          else begin
            e = sb.pop_front();
            chk(e.tag, "gain_idx", gain_idx, e.idx);
            chk(e.tag, "gain_chg", gain_chg, e.chg);
            chk(e.tag, "settled",  settled,  e.st);
          end
        end else begin
          #1;
          chk("R7", "idle gain_chg", gain_chg, 0);
          chk("R7", "idle gain_idx", gain_idx, ref_idx);
          chk("R8", "idle settled", settled, ref_st);
        end
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset gain_idx", gain_idx, 3);
    chk("R1", "reset gain_chg", gain_chg, 0);
    chk("R1", "reset settled", settled, 0);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R1", "post-reset gain_idx", gain_idx, 3);
    idle(2);
    send(32'h0000_0000, "R6");           // raise at top ignored
    idle(2);
    send(32'hFF00_0000, "R2");           // two clip -> 2
    idle(1);
    send(32'h1111_111F, "R3");           // single clip holds
    idle(1);
    send(32'hF0F0_F000, "R2");           // -> 1
    send(32'hF0F0_0000, "R2");           // back-to-back -> 0
    idle(2);
    send(32'hFFFF_FFFF, "R5");           // floor holds
    idle(1);
    send(32'hEEEE_EEEE, "R9");           // 1110 not full scale
    send(32'h0000_0100, "R9");           // one nonzero blocks raise
    idle(1);
    send(32'h0000_0000, "R4");           // -> 1
    send(32'h0000_0000, "R4");           // -> 2
    idle(3);
    send(32'hFFFF_FFFF, "R7");           // all clip: single step -> 1
    idle(1);
    send(32'h0000_0000, "R8");           // -> 2, settled low
    send(32'h0000_0000, "R4");           // -> 3
    send(32'h0000_0000, "R6");           // top holds
    idle(4);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule